// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block collects interrupt requests from a set of sources spread over four request levels, with up to 32 sources per level. Each source has its own set strobe. A request stays pending until it is acknowledged or the block is reset. For every level the block drives a pending flag, which the priority logic outside the block compares against the processor priority.

When the processor acknowledges a level, the block picks the lowest-numbered pending source on that level. It clears only that source's request and returns a vector one cycle later. The base vector is either a per-source static value or, for sources configured to supply their own, a dynamic value from that source. The block then ORs in a per-source set of forced bits and masks the result. Every bit outside the keep mask is dropped unless the forced bits hold it.

Top module: `irq_vector_gen`

## Requirements
- R1: `pend_o[l]` is high in a cycle exactly when level `l` has at least one pending request.
- R2: While `rst_ni` is low, and in the first cycle after it rises, all pending requests are clear, `pend_o` is zero and `vec_valid_o` is low.
- R3: An acknowledge on level `l` selects the pending source with the smallest index on that level and clears that request alone. Other pending requests on the level stay pending.
- R4: `vec_valid_o` is high for exactly one cycle, in the cycle after each acknowledge, and is low otherwise.
- R5: If the selected source's dynamic-enable bit is set, its `dyn_vec_i` slice is the base vector. Otherwise its `def_vec_i` slice is the base vector.
- R6: The returned vector is `(base | forced) & (forced | KEEP_MASK)`, where `forced` is the source's `frc_i` slice and `KEEP_MASK` defaults to 0x1FC.
- R7: An acknowledge on a level with no pending request returns vector 0, with `vec_valid_o` high.
- R8: If a source's set strobe and the clear from its own acknowledge fall in the same cycle, the request remains pending.
- R9: An acknowledge on one level leaves the pending requests of every other level unchanged.
- R10: Source `s` of level `l` uses the flat index `l*N_SRC+s`. Bit `l*N_SRC+s` of `set_i` and `dyn_en_i` belongs to that source. Its slices of `def_vec_i`, `dyn_vec_i` and `frc_i` are bits `[(l*N_SRC+s)*VEC_W +: VEC_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | N_LVL*N_SRC | Per-source request set strobes |
| ack_i | input | 1 | Acknowledge strobe |
| ack_lvl_i | input | LVL_W | Level being acknowledged |
| def_vec_i | input | N_LVL*N_SRC*VEC_W | Per-source static vectors |
| dyn_en_i | input | N_LVL*N_SRC | Per-source dynamic-vector enables |
| dyn_vec_i | input | N_LVL*N_SRC*VEC_W | Per-source dynamic vectors |
| frc_i | input | N_LVL*N_SRC*VEC_W | Per-source forced vector bits |
| pend_o | output | N_LVL | Per-level pending flags |
| vec_o | output | VEC_W | Returned vector |
| vec_valid_o | output | 1 | Vector valid, one cycle after an acknowledge |

## Verification
The bench builds the block with N_LVL=4, N_SRC=8 and VEC_W=12. With eight sources per level, one short sequence can fill a whole level, including its highest index, and drain it in priority order down to the empty case. The 12-bit vector width leaves bits above the keep mask, so both the masking and the forced bits that survive it are visible. Static, dynamic and forced configurations differ per source, and the bench compares every returned vector against its own model.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned VEC_KEEP_DEFAULT = 32'h1FC;
  typedef enum logic {BASE_STATIC = 1'b0, BASE_DYNAMIC = 1'b1} base_sel_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             any_o
);
  logic [N_SRC-1:0] mask_q;

  // set beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q & ~clr_i) | set_i;
  end

  assign mask_o = mask_q;
  assign any_o  = |mask_q;
endmodule

// File: rtl/irq_lowest_sel.sv
module irq_lowest_sel #(
  parameter int N_SRC = 32,
  parameter int SRC_W = 5
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             found_o,
  output logic [SRC_W-1:0] idx_o,
  output logic [N_SRC-1:0] onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = SRC_W'(i);
    end
  end

  assign onehot_o = req_i & (~req_i + N_SRC'(1));
  assign found_o  = |req_i;
endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge
  import irq_vec_pkg::*;
#(
  parameter int             VEC_W     = 16,
  parameter logic [VEC_W-1:0] KEEP_MASK = VEC_W'(VEC_KEEP_DEFAULT)
) (
  input  logic             use_dyn_i,
  input  logic [VEC_W-1:0] stat_vec_i,
  input  logic [VEC_W-1:0] dyn_vec_i,
  input  logic [VEC_W-1:0] frc_i,
  output logic [VEC_W-1:0] vec_o
);
  base_sel_e        sel;
  logic [VEC_W-1:0] base;

  assign sel   = base_sel_e'(use_dyn_i);
  assign base  = (sel == BASE_DYNAMIC) ? dyn_vec_i : stat_vec_i;
  assign vec_o = (base | frc_i) & (frc_i | KEEP_MASK);
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_vec_pkg::*;
#(
  parameter int N_LVL = 4,
  parameter int N_SRC = 32,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] KEEP_MASK = VEC_W'(VEC_KEEP_DEFAULT),
  localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int N_TOT = N_LVL * N_SRC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_TOT-1:0]       set_i,
  input  logic                   ack_i,
  input  logic [LVL_W-1:0]       ack_lvl_i,
  input  logic [N_TOT*VEC_W-1:0] def_vec_i,
  input  logic [N_TOT-1:0]       dyn_en_i,
  input  logic [N_TOT*VEC_W-1:0] dyn_vec_i,
  input  logic [N_TOT*VEC_W-1:0] frc_i,
  output logic [N_LVL-1:0]       pend_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   vec_valid_o
);
  logic [N_SRC-1:0] lvl_mask [N_LVL];
  logic [N_SRC-1:0] sel_req, sel_onehot;
  logic [SRC_W-1:0] sel_idx;
  logic             sel_found, lvl_ok;
  logic [VEC_W-1:0] stat_vec, dyn_vec, frc_vec, merged, vec_d;
  logic             use_dyn;
  int               flat;
  logic [VEC_W-1:0] vec_q;
  logic             valid_q;

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    logic [N_SRC-1:0] clr;
    assign clr = (ack_i && ack_lvl_i == LVL_W'(l)) ? sel_onehot : '0;
    irq_pend_bank #(.N_SRC(N_SRC)) bank_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_i[l*N_SRC +: N_SRC]),
      .clr_i  (clr),
      .mask_o (lvl_mask[l]),
      .any_o  (pend_o[l])
    );
  end

  assign lvl_ok  = int'(ack_lvl_i) < N_LVL;
  assign sel_req = lvl_ok ? lvl_mask[ack_lvl_i] : '0;

  irq_lowest_sel #(.N_SRC(N_SRC), .SRC_W(SRC_W)) sel_i (
    .req_i    (sel_req),
    .found_o  (sel_found),
    .idx_o    (sel_idx),
    .onehot_o (sel_onehot)
  );

  always_comb begin
    flat = lvl_ok ? (int'(ack_lvl_i) * N_SRC + int'(sel_idx)) : 0;
    stat_vec = def_vec_i[flat*VEC_W +: VEC_W];
    dyn_vec  = dyn_vec_i[flat*VEC_W +: VEC_W];
    frc_vec  = frc_i[flat*VEC_W +: VEC_W];
    use_dyn  = dyn_en_i[flat];
  end

  irq_vec_merge #(.VEC_W(VEC_W), .KEEP_MASK(KEEP_MASK)) merge_i (
    .use_dyn_i  (use_dyn),
    .stat_vec_i (stat_vec),
    .dyn_vec_i  (dyn_vec),
    .frc_i      (frc_vec),
    .vec_o      (merged)
  );

  assign vec_d = sel_found ? merged : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ack_i;
      if (ack_i) vec_q <= vec_d;
    end
  end

  assign vec_o       = vec_q;
  assign vec_valid_o = valid_q;
endmodule

// File: rtl/irq_vector_gen_chk.sv
module irq_vector_gen_chk #(
  parameter int N_LVL = 4,
  parameter int N_SRC = 32,
  parameter int VEC_W = 16,
  parameter int LVL_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_LVL*N_SRC-1:0] set_i,
  input logic                   ack_i,
  input logic [LVL_W-1:0]       ack_lvl_i,
  input logic [N_LVL-1:0]       pend_o,
  input logic [VEC_W-1:0]       vec_o,
  input logic                   vec_valid_o
);
  p_valid_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o);
  p_no_spurious_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_valid_o);
  p_empty_ack_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int'(ack_lvl_i) < N_LVL && !pend_o[ack_lvl_i]) |=> (vec_o == '0));

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    p_pend_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_o[l]) |-> $past(|set_i[l*N_SRC +: N_SRC]));
    p_pend_fall_own_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_o[l]) |-> $past(ack_i && ack_lvl_i == LVL_W'(l)));
  end
endmodule

bind irq_vector_gen irq_vector_gen_chk #(
  .N_LVL(N_LVL), .N_SRC(N_SRC), .VEC_W(VEC_W), .LVL_W(LVL_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .ack_i(ack_i),
  .ack_lvl_i(ack_lvl_i), .pend_o(pend_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
);

// File: tb/irq_vector_gen_tb.sv
module irq_vector_gen_tb_top;
  localparam int NL = 4, NS = 8, VW = 12, NT = NL * NS;
  localparam logic [VW-1:0] KEEP = 12'h1FC;

  logic clk = 1'b0, rst_ni = 1'b0, ack = 1'b0;
  logic [1:0] ack_lvl = '0;
  logic [NT-1:0] set = '0, dyn_en;
  logic [NT*VW-1:0] def_vec, dyn_vec, frc;
  logic [NL-1:0] pend;
  logic [VW-1:0] vec;
  logic vec_valid;

  int n_run = 0, n_fail = 0;
  logic [NS-1:0] mdl [NL];
  logic [VW-1:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  irq_vector_gen #(.N_LVL(NL), .N_SRC(NS), .VEC_W(VW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .set_i(set), .ack_i(ack), .ack_lvl_i(ack_lvl),
    .def_vec_i(def_vec), .dyn_en_i(dyn_en), .dyn_vec_i(dyn_vec), .frc_i(frc),
    .pend_o(pend), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  function automatic logic [VW-1:0] cfg_def(int l, int s);
    return VW'(12'h600 | (l << 6) | (s << 2) | 1);
  endfunction
  function automatic logic [VW-1:0] cfg_dyn(int l, int s);
    return VW'(12'hA53 ^ (s << 3) ^ (l << 2));
  endfunction
  function automatic logic [VW-1:0] cfg_frc(int l, int s);
    return (s == 3) ? 12'h802 : (s == 6 ? 12'h003 : 12'h000);
  endfunction
  function automatic logic cfg_dyn_en(int l, int s);
    return (s == 5) || (l == 2 && s == 1);
  endfunction

  function automatic void check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic logic [3:0] pend_exp();
    logic [3:0] p;
    for (int l = 0; l < NL; l++) p[l] = |mdl[l];
    return p;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && vec_valid) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected valid", 32'(vec_valid), 32'd0);
      end else begin
        string t;
        logic [VW-1:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(vec), 32'(e));
      end
    end
  end

  // driver: called at a negedge, returns at the next negedge
  task automatic step(input logic [NT-1:0] s, input logic a, input int l, input string t);
    logic [NS-1:0] clr;
    clr = '0;
    if (a) begin
      logic [VW-1:0] e, b, f;
      int src;
      src = -1;
      for (int i = NS - 1; i >= 0; i--) if (mdl[l][i]) src = i;
      if (src < 0) e = '0;
      else begin
        b = cfg_dyn_en(l, src) ? cfg_dyn(l, src) : cfg_def(l, src);
        f = cfg_frc(l, src);
        e = (b | f) & (f | KEEP);
        clr[src] = 1'b1;
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    set = s; ack = a; ack_lvl = 2'(l);
    @(posedge clk);
    for (int k = 0; k < NL; k++)
      mdl[k] = (mdl[k] & ((k == l) ? ~clr : '1)) | s[k*NS +: NS];
    @(negedge clk);
    set = '0; ack = 1'b0;
    check("R1 pend", 32'(pend), 32'(pend_exp()));
  endtask

  function automatic logic [NT-1:0] sb(int l, logic [NS-1:0] m);
    logic [NT-1:0] v;
    v = '0;
    v[l*NS +: NS] = m;
    return v;
  endfunction

  initial begin
    for (int l = 0; l < NL; l++) begin
      mdl[l] = '0;
      for (int s = 0; s < NS; s++) begin
        def_vec[(l*NS+s)*VW +: VW] = cfg_def(l, s);
        dyn_vec[(l*NS+s)*VW +: VW] = cfg_dyn(l, s);
        frc[(l*NS+s)*VW +: VW]     = cfg_frc(l, s);
        dyn_en[l*NS+s]             = cfg_dyn_en(l, s);
      end
    end
    repeat (3) @(negedge clk);
    check("R2 pend in reset", 32'(pend), 0);
    check("R2 valid in reset", 32'(vec_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2 pend after reset", 32'(pend), 0);

    // R3 R5 R6: drain level 1 in index order, then R7 empty
    step(sb(1, 8'b1010_1010), 1'b0, 0, "R1 set");
    step('0, 1'b1, 1, "R3 R6 src1");
    step('0, 1'b1, 1, "R3 R6 src3 forced");
    step('0, 1'b1, 1, "R5 src5 dynamic");
    step('0, 1'b1, 1, "R3 src7 highest");
    step('0, 1'b1, 1, "R7 empty level");
    step('0, 1'b0, 0, "R4 idle");
    check("R4 valid low when idle", 32'(vec_valid), 0);

    // R9: acks on level 2 leave levels 0 and 3
    step(sb(0, 8'h41) | sb(2, 8'h06) | sb(3, 8'h80), 1'b0, 0, "R1 set multi");
    step('0, 1'b1, 2, "R5 R9 lvl2 src1 dynamic");
    step('0, 1'b1, 2, "R9 lvl2 src2");
    check("R9 other levels kept", 32'({mdl[0], mdl[3]}), 32'({8'h41, 8'h80}));
    step('0, 1'b1, 0, "R3 R10 lvl0 src0");
    step('0, 1'b1, 0, "R6 lvl0 src6 forced low bits");

    // R8: set and clear on the same bit
    step(sb(3, 8'h01), 1'b0, 0, "R1 set lvl3 src0");
    step(sb(3, 8'h01), 1'b1, 3, "R8 ack with set");
    check("R8 still pending", 32'(pend[3]), 1);
    step('0, 1'b1, 3, "R8 src0 again");
    step('0, 1'b1, 3, "R3 lvl3 src7");
    step('0, 1'b1, 3, "R7 lvl3 empty");

    // full level then back-to-back acks
    step(sb(2, 8'hFF), 1'b0, 0, "R1 set all lvl2");
    for (int i = 0; i < NS; i++) step('0, 1'b1, 2, "R3 R6 drain lvl2");
    step('0, 1'b0, 0, "R4 idle");
    check("R3 scoreboard drained", 32'(exp_q.size()), 0);

    // R2: reset with requests pending
    step(sb(0, 8'h18) | sb(1, 8'h02), 1'b0, 0, "R1 set before reset");
    rst_ni = 1'b0;
    for (int l = 0; l < NL; l++) mdl[l] = '0;
    @(negedge clk);
    check("R2 pend cleared by reset", 32'(pend), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2 valid low after reset", 32'(vec_valid), 0);
    step('0, 1'b1, 0, "R2 R7 empty after reset");
    step('0, 1'b0, 0, "R4 idle");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule